// File: doc/BRIEF.md
# Hill Peak Detector

This block watches one image row at a time, delivered as a stream of smoothed 8-bit intensity samples, and looks for hills: stretches where the intensity climbs and then drops again, with no second climb inside the drop. Each finished hill is measured three ways: how far it rose above its starting sample, how far it fell to its final sample, and how many columns it spans. A hill that rises and falls by at least the height threshold, and spans no more than the width threshold, has its centre column marked as a peak.

A hill is only known once a new climb closes it. For that reason the marks for a row are collected in a bitmap and sent out while the next row streams in. The flag for column c of row k comes out beside column c of row k+1, one clock after that sample is accepted. Candidate state is dropped whenever a new row starts, so a hill that is still open at the end of its row never produces a mark.

Top module: `hill_peak_detector`

## Requirements
- R1: While reset is high, and on the first cycle after it, `o_vld`, `o_sor` and `o_peak` are all low.
- R2: A hill starts at the sample just before the first climb and ends at the last sample of its descent, which is the sample just before the next climb. When accepted, its flag is set at column floor((start + end) / 2).
- R3: A hill is rejected unless its peak value minus its start value is at least `i_thr_h`. A difference equal to the threshold is accepted.
- R4: A hill is rejected unless its peak value minus its end value is at least `i_thr_h`. A difference equal to the threshold is accepted.
- R5: A hill is rejected unless end column minus start column is at most `i_thr_w`. A difference equal to the threshold is accepted.
- R6: A sample equal to the one before it leaves the current climb or descent running. It neither ends the hill nor moves the peak.
- R7: A climb that follows a descent closes the open hill. The same valley sample then becomes the start of the next hill, so two neighbouring hills can share one valley.
- R8: A sample with `i_sor` high clears all candidate state. A hill still rising or falling when its row ends produces no flag, and the new row's first sample closes nothing.
- R9: For each accepted sample, `o_vld` is high one cycle later and `o_sor` repeats `i_sor`. `o_peak` then carries the flag of the same column of the previous row. During the first row after reset it is 0, and it is low whenever `o_vld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| i_vld | input | 1 | Sample valid |
| i_sor | input | 1 | First sample of a row (qualified by `i_vld`) |
| i_pix | input | 8 | Smoothed intensity sample |
| i_thr_h | input | 8 | Minimum rise and fall of a hill |
| i_thr_w | input | CW = log2(COLS) | Maximum span of a hill in columns |
| o_vld | output | 1 | Output flag valid |
| o_sor | output | 1 | Output flag is column 0 |
| o_peak | output | 1 | Peak flag for this column of the previous row |

## Verification
The bench probes three kinds of boundary: heights exactly at the threshold and one step above it on each side separately, and a span exactly at the width limit and one column over it. A design using a strict comparison, or one that tests the same side twice, drops a flag or keeps one it should not.

Flat runs at the summit and in the valley are exercised directly. A design that treats equal samples as a turn closes the hill early and marks the wrong centre. Back-to-back hills sharing a valley, and a hill still falling when the row ends, expose designs that lose the shared start point or leak state into the next row.

Random-walk rows with idle gaps check that the flags stay column-aligned with the following row.

// File: rtl/hill_pkg.sv
package hill_pkg;

    localparam int PIX_W = 8;

    typedef logic [PIX_W-1:0] pix_t;

    typedef enum logic [1:0] {
        PH_NONE = 2'd0,
        PH_RISE = 2'd1,
        PH_FALL = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        pix_t   start_v;
        pix_t   top_v;
    } cand_t;

    // Both flanks of a closed hill must clear the height limit.
    function automatic logic flanks_ok(pix_t top, pix_t lo_l, pix_t lo_r, pix_t thr);
        pix_t rise_amt;
        pix_t fall_amt;
        rise_amt = top - lo_l;
        fall_amt = top - lo_r;
        return (rise_amt >= thr) && (fall_amt >= thr);
    endfunction

endpackage

// File: rtl/hill_tracker.sv
module hill_tracker
    import hill_pkg::*;
#(
    parameter int COLS = 64,
    parameter int CW   = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          i_vld,
    input  logic          i_sor,
    input  pix_t          i_pix,
    input  pix_t          i_thr_h,
    input  logic [CW-1:0] i_thr_w,
    output logic          o_mark,
    output logic [CW-1:0] o_mark_col,
    output logic [CW-1:0] o_col
);

    cand_t         cand_q;
    pix_t          prev_q;
    logic [CW-1:0] col_q;
    logic [CW-1:0] start_c_q;
    logic          in_row_q;

    logic [CW-1:0] end_c;
    logic [CW-1:0] span;
    logic [CW:0]   col_sum;
    logic          step_up;
    logic          step_down;
    logic          closes;

    always_comb begin
        end_c     = col_q - 1'b1;
        span      = end_c - start_c_q;
        col_sum   = {1'b0, start_c_q} + {1'b0, end_c};
        step_up   = i_pix > prev_q;
        step_down = i_pix < prev_q;
        closes    = i_vld && !i_sor && in_row_q && (cand_q.phase == PH_FALL) && step_up;
        o_mark    = closes && flanks_ok(cand_q.top_v, cand_q.start_v, prev_q, i_thr_h)
                    && (span <= i_thr_w);
        o_mark_col = col_sum[CW:1];
        o_col      = col_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q    <= '{phase: PH_NONE, start_v: '0, top_v: '0};
            prev_q    <= '0;
            col_q     <= '0;
            start_c_q <= '0;
            in_row_q  <= 1'b0;
        end else if (i_vld) begin
            if (i_sor) begin
                cand_q.phase <= PH_NONE;
                prev_q       <= i_pix;
                col_q        <= CW'(1);
                in_row_q     <= 1'b1;
            end else if (in_row_q) begin
                prev_q <= i_pix;
                col_q  <= col_q + 1'b1;
                unique case (cand_q.phase)
                    PH_NONE: if (step_up) begin
                        cand_q.phase   <= PH_RISE;
                        cand_q.start_v <= prev_q;
                        start_c_q      <= end_c;
                    end
                    PH_RISE: if (step_down) begin
                        cand_q.phase <= PH_FALL;
                        cand_q.top_v <= prev_q;
                    end
                    PH_FALL: if (step_up) begin
                        cand_q.phase   <= PH_RISE;
                        cand_q.start_v <= prev_q;
                        start_c_q      <= end_c;
                    end
                    default: cand_q.phase <= PH_NONE;
                endcase
            end
        end
    end

    // R2: a descent can only follow a climb
    p_fall_from_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cand_q.phase == PH_FALL) |-> $past(cand_q.phase) == PH_RISE)
        else $error("descent entered without a climb");

    // R2: an open candidate always starts left of the next column
    p_start_before_col_r2: assert property (@(posedge clk) disable iff (rst)
        (cand_q.phase != PH_NONE && col_q != '0) |-> start_c_q < col_q)
        else $error("start column not behind current column");

    // R2: a mark always lands on an already seen column
    p_mark_behind_r2: assert property (@(posedge clk) disable iff (rst)
        o_mark |-> o_mark_col < col_q)
        else $error("mark column ahead of stream");

    // R8: a row start leaves no open candidate
    p_row_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (i_vld && i_sor) |=> cand_q.phase == PH_NONE)
        else $error("candidate survived row start");

endmodule

// File: rtl/peak_map.sv
module peak_map #(
    parameter int COLS = 64,
    parameter int CW   = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          i_vld,
    input  logic          i_sor,
    input  logic [CW-1:0] i_col,
    input  logic          i_mark,
    input  logic [CW-1:0] i_mark_col,
    output logic          o_vld,
    output logic          o_sor,
    output logic          o_peak
);

    logic [COLS-1:0] wr_q;
    logic [COLS-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= '0;
            rd_q   <= '0;
            o_vld  <= 1'b0;
            o_sor  <= 1'b0;
            o_peak <= 1'b0;
        end else begin
            o_vld  <= i_vld;
            o_sor  <= i_vld && i_sor;
            o_peak <= 1'b0;
            if (i_vld) begin
                if (i_sor) begin
                    rd_q   <= wr_q;
                    wr_q   <= '0;
                    o_peak <= wr_q[0];
                end else begin
                    o_peak <= rd_q[i_col];
                    if (i_mark) wr_q[i_mark_col] <= 1'b1;
                end
            end
        end
    end

    // R9: completed row map moves to the read side at row start
    p_swap_r9: assert property (@(posedge clk) disable iff (rst)
        (i_vld && i_sor) |=> rd_q == $past(wr_q))
        else $error("row map not handed over");

    // R8: new row starts with an empty map
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (i_vld && i_sor) |=> wr_q == '0)
        else $error("write map not cleared");

    // R8: tracker never closes a hill on a row start
    p_no_mark_on_sor_r8: assert property (@(posedge clk) disable iff (rst)
        i_mark |-> (i_vld && !i_sor))
        else $error("mark on row start or idle");

    // R9: idle input yields an idle output
    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !i_vld |=> (!o_vld && !o_peak))
        else $error("output active after idle cycle");

endmodule

// File: rtl/hill_peak_detector.sv
module hill_peak_detector
    import hill_pkg::*;
#(
    parameter int COLS = 64,
    parameter int CW   = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          i_vld,
    input  logic          i_sor,
    input  logic [7:0]    i_pix,
    input  logic [7:0]    i_thr_h,
    input  logic [CW-1:0] i_thr_w,
    output logic          o_vld,
    output logic          o_sor,
    output logic          o_peak
);

    logic          mark;
    logic [CW-1:0] mark_col;
    logic [CW-1:0] col;

    hill_tracker #(.COLS(COLS), .CW(CW)) u_track (
        .clk        (clk),
        .rst        (rst),
        .i_vld      (i_vld),
        .i_sor      (i_sor),
        .i_pix      (i_pix),
        .i_thr_h    (i_thr_h),
        .i_thr_w    (i_thr_w),
        .o_mark     (mark),
        .o_mark_col (mark_col),
        .o_col      (col)
    );

    peak_map #(.COLS(COLS), .CW(CW)) u_map (
        .clk        (clk),
        .rst        (rst),
        .i_vld      (i_vld),
        .i_sor      (i_sor),
        .i_col      (col),
        .i_mark     (mark),
        .i_mark_col (mark_col),
        .o_vld      (o_vld),
        .o_sor      (o_sor),
        .o_peak     (o_peak)
    );

    // R9: a flag is only ever presented with a valid output
    p_peak_valid_r9: assert property (@(posedge clk) disable iff (rst)
        o_peak |-> o_vld)
        else $error("peak flag without valid");

    // R1: first cycle out of reset is quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!o_vld && !o_sor && !o_peak))
        else $error("outputs active after reset");

endmodule

// File: tb/hill_peak_detector_tb.sv
`timescale 1ns/1ps
module hill_peak_detector_tb;

    localparam int COLS = 64;
    localparam int CW   = $clog2(COLS);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          i_vld = 1'b0;
    logic          i_sor = 1'b0;
    logic [7:0]    i_pix = '0;
    logic [7:0]    i_thr_h = '0;
    logic [CW-1:0] i_thr_w = '0;
    logic          o_vld, o_sor, o_peak;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [7:0]      rowbuf [COLS];
    logic [COLS-1:0] prev_exp;
    logic [COLS-1:0] got;
    logic [COLS-1:0] exp_now;
    string           prev_tag;
    bit              bubbles = 0;

    always #4 clk = ~clk;

    hill_peak_detector #(.COLS(COLS)) u_dut (
        .clk(clk), .rst(rst), .i_vld(i_vld), .i_sor(i_sor), .i_pix(i_pix),
        .i_thr_h(i_thr_h), .i_thr_w(i_thr_w),
        .o_vld(o_vld), .o_sor(o_sor), .o_peak(o_peak)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Expected flag map of rowbuf, from the hill rules.
    function automatic logic [COLS-1:0] ref_row(input int th, input int tw);
        logic [COLS-1:0] m;
        int ph, sc, sv, tv;
        m = '0; ph = 0; sc = 0; sv = 0; tv = 0;
        for (int c = 1; c < COLS; c++) begin
            int x;
            int p;
            x = int'(rowbuf[c]);
            p = int'(rowbuf[c-1]);
            if (ph == 0) begin
                if (x > p) begin ph = 1; sc = c - 1; sv = p; end
            end else if (ph == 1) begin
                if (x < p) begin ph = 2; tv = p; end
            end else begin
                if (x > p) begin
                    if ((tv - sv) >= th && (tv - p) >= th && (c - 1 - sc) <= tw)
                        m[(sc + c - 1) / 2] = 1'b1;
                    ph = 1; sc = c - 1; sv = p;
                end
            end
        end
        return m;
    endfunction

    task automatic send_row(output logic [COLS-1:0] flags);
        flags = '0;
        for (int c = 0; c < COLS; c++) begin
            if (bubbles && ($urandom % 5 == 0)) begin
                i_vld = 1'b0;
                @(posedge clk); #1;
                check(!o_vld && !o_peak, "R9 idle", {62'd0, o_vld, o_peak}, 64'd0);
                @(negedge clk);
            end
            i_vld = 1'b1;
            i_sor = (c == 0);
            i_pix = rowbuf[c];
            @(posedge clk); #1;
            flags[c] = o_peak;
            if (o_vld !== 1'b1 || o_sor !== (c == 0)) begin
                check(1'b0, "R9 vld/sor", {62'd0, o_vld, o_sor}, {62'd0, 1'b1, c == 0});
            end
            @(negedge clk);
        end
        i_vld = 1'b0;
        i_sor = 1'b0;
    endtask

    task automatic fill(input int v);
        for (int c = 0; c < COLS; c++) rowbuf[c] = 8'(v);
    endtask

    // Sends the row in rowbuf and compares the map of the row before it.
    task automatic run_row(input int th, input int tw, input string tag);
        i_thr_h = 8'(th);
        i_thr_w = CW'(tw);
        exp_now = ref_row(th, tw);
        send_row(got);
        check(got == prev_exp, prev_tag, got, prev_exp);
        prev_exp = exp_now;
        prev_tag = tag;
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        check(!o_vld && !o_sor && !o_peak, "R1 in reset", {61'd0, o_vld, o_sor, o_peak}, 64'd0);
        rst = 1'b0;
        @(posedge clk); #1;
        check(!o_vld && !o_sor && !o_peak, "R1 after reset", {61'd0, o_vld, o_sor, o_peak}, 64'd0);
        @(negedge clk);

        prev_exp = '0;
        prev_tag = "R9 first row empty";

        // R2: single hill start 4 end 9, centre 6; trailing climb left open
        fill(10);
        rowbuf[5] = 20; rowbuf[6] = 30; rowbuf[7] = 20;
        for (int c = 10; c < COLS; c++) rowbuf[c] = 40;
        exp_now = ref_row(5, 10);
        check(exp_now == 64'(64'h1 << 6), "R2 centre", exp_now, 64'(64'h1 << 6));
        run_row(5, 10, "R2 hill");

        // R3: left rise 10, right fall 15, span 4, centre 4
        fill(30);
        rowbuf[0] = 10; rowbuf[1] = 10; rowbuf[2] = 10;
        rowbuf[3] = 15; rowbuf[4] = 20; rowbuf[5] = 12; rowbuf[6] = 5;
        exp_now = ref_row(10, 10);
        check(exp_now == 64'(64'h1 << 4), "R3 equal accepted", exp_now, 64'(64'h1 << 4));
        run_row(10, 10, "R3 left equal");
        exp_now = ref_row(11, 10);
        check(exp_now == 64'd0, "R3 over rejected", exp_now, 64'd0);
        run_row(11, 10, "R3 left short");

        // R5: same hill, span 4 against width limit
        run_row(5, 4, "R5 width equal");
        exp_now = ref_row(5, 3);
        check(exp_now == 64'd0, "R5 wide rejected", exp_now, 64'd0);
        run_row(5, 3, "R5 too wide");

        // R4: left rise 15, right fall 10
        fill(30);
        rowbuf[0] = 5; rowbuf[1] = 5; rowbuf[2] = 5;
        rowbuf[3] = 12; rowbuf[4] = 20; rowbuf[5] = 15; rowbuf[6] = 10;
        exp_now = ref_row(10, 10);
        check(exp_now == 64'(64'h1 << 4), "R4 equal accepted", exp_now, 64'(64'h1 << 4));
        run_row(10, 10, "R4 right equal");
        run_row(11, 10, "R4 right short");

        // R6: flat summit and flat valley, start 0 end 9, centre 4
        fill(50);
        rowbuf[0] = 0; rowbuf[1] = 10; rowbuf[2] = 10; rowbuf[3] = 20; rowbuf[4] = 20;
        rowbuf[5] = 20; rowbuf[6] = 10; rowbuf[7] = 10; rowbuf[8] = 0; rowbuf[9] = 0;
        exp_now = ref_row(15, 20);
        check(exp_now == 64'(64'h1 << 4), "R6 flats", exp_now, 64'(64'h1 << 4));
        run_row(15, 20, "R6 flats");

        // R7: two hills sharing valley at column 2, centres 1 and 3
        fill(20);
        rowbuf[0] = 0; rowbuf[1] = 20; rowbuf[2] = 0; rowbuf[3] = 20; rowbuf[4] = 0;
        exp_now = ref_row(10, 10);
        check(exp_now == 64'h000000000000000a, "R7 shared valley", exp_now, 64'h000000000000000a);
        run_row(10, 10, "R7 shared valley");

        // R8: hill still falling at row end, then a row that climbs at once
        fill(0);
        rowbuf[60] = 10; rowbuf[61] = 20; rowbuf[62] = 10; rowbuf[63] = 5;
        run_row(1, 20, "R8 open at row end");
        fill(60);
        rowbuf[0] = 50;
        run_row(1, 20, "R8 new row clears");

        // Random-walk rows with idle gaps
        bubbles = 1;
        for (int r = 0; r < 30; r++) begin
            v = int'($urandom % 256);
            for (int c = 0; c < COLS; c++) begin
                v = v + int'($urandom % 21) - 10;
                if (v < 0) v = 0;
                if (v > 255) v = 255;
                rowbuf[c] = 8'(v);
            end
            run_row(int'($urandom % 16), int'($urandom % COLS), "R2 random");
        end
        bubbles = 0;

        fill(0);
        run_row(0, 0, "R9 flush");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule